// File: doc/BRIEF.md
# SDRAM Read Data Output Pipeline

This block is the device-side read path of a synchronous DRAM model. A controller-facing command decoder hands it a one-cycle strobe for each accepted READ, together with the bank, the auto-precharge flag, a burst-length code and the current CAS latency. The array core supplies one data word per clock for every beat of the burst. The block counts out the beats and delays each word by the CAS latency before it drives the word onto the data bus with an output enable.

A per-cycle mask input turns the output driver off two clocks after it is sampled. The beat itself still advances. A burst can be cut short by a burst-stop strobe, or by a precharge to the bank being read when that read was issued without auto-precharge. The cut takes effect on the bus one CAS latency later, because it only stops new beats from entering the pipeline. A READ that arrives while a burst is still running replaces the rest of that burst. Its first beat follows the previous beat with no idle cycle on the bus.

Top module: `sdram_rd_pipe`

## Requirements
- R1: While `rst_n` is low, `beat_valid`, `dq_oe` and `dq_out` are all zero, and no beat from before the reset appears after it is released.
- R2: With `lat_code` = 2 at the READ, the word on `core_dq` at the k-th clock edge counting from the READ edge (k = 0 at the READ edge) is shown on `dq_out` during the cycle after edge n+k+1, where n is the READ edge.
- R3: With `lat_code` = 3, that word is shown one cycle later than under R2, during the cycle after edge n+k+2.
- R4: Only `lat_code` values 2 and 3 are accepted. A `rd_go` with any other code is ignored and does not change a burst in progress.
- R5: `burst_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8.
- R6: `mask_in` high at edge d holds `dq_oe` low and `dq_out` at zero during the cycle after edge d+1. `beat_valid` and the beat count are not affected.
- R7: `stop_req` at edge t prevents beats for edges t and later. `beat_valid` is low in the cycle that would have shown the beat of edge t.
- R8: `pc_req` at edge t truncates the burst like R7 only when `pc_bank` equals `rd_bank` of the running burst and that READ had `rd_autopc` low. Otherwise it is ignored.
- R9: An accepted READ during a burst drops the old burst's beats from its own edge onward. The old burst's last beat and the new burst's first beat occupy adjacent bus cycles.
- R10: `dq_oe` is high only in cycles where `beat_valid` is high, and `dq_out` is zero whenever `dq_oe` is low.
- R11: When an accepted READ and `stop_req` or `pc_req` share an edge, the READ wins and its burst runs in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_go | input | 1 | READ command strobe, one cycle |
| rd_bank | input | BANK_W | Bank addressed by the READ |
| rd_autopc | input | 1 | READ carries auto-precharge |
| burst_code | input | 2 | Burst length code (R5) |
| lat_code | input | 2 | CAS latency, 2 or 3 |
| core_dq | input | DW | Array word for the current beat |
| mask_in | input | 1 | Read output mask |
| stop_req | input | 1 | Burst-stop command strobe |
| pc_req | input | 1 | Precharge command strobe |
| pc_bank | input | BANK_W | Bank addressed by the precharge |
| dq_out | output | DW | Read data to the bus |
| dq_oe | output | 1 | Output driver enable |
| beat_valid | output | 1 | A read beat is due this cycle |

## Verification
Two pairs of behaviours can fall in the same cycle. A READ and a burst stop can be registered on one edge. The mask can also be raised while a burst is still running, so that masked cycles fall in the run-up to a truncation. The bench provokes the first pair by issuing both strobes on one edge, and judges it by a full two-beat burst with no early end. It provokes the second by raising the mask two edges before a burst stop. The expected bus trace then shows a beat that is still counted but not driven, followed by the remaining beats and a clean stop one CAS latency after the stop strobe.

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DW        = 16,
  parameter int BANK_W    = 2,
  parameter int MAX_BURST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic              rd_autopc,
  input  logic [1:0]        burst_code,
  input  logic [1:0]        lat_code,
  input  logic [DW-1:0]     core_dq,
  input  logic              mask_in,
  input  logic              stop_req,
  input  logic              pc_req,
  input  logic [BANK_W-1:0] pc_bank,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  output logic              beat_valid
);
  localparam int CNT_W = $clog2(MAX_BURST);
  localparam int NSTG  = 3;

  logic [CNT_W-1:0]  left_q;
  logic [BANK_W-1:0] bank_q;
  logic              apc_q;
  logic [1:0]        lat_q;
  logic [1:0]        msk_q;
  logic [NSTG-1:0]   sv;
  logic [DW-1:0]     sd [NSTG];

  logic              lat_ok, accept, cut, slot;
  logic [CNT_W-1:0]  beats_m1;
  logic [1:0]        sel;

  assign lat_ok   = (lat_code == 2'd2) || (lat_code == 2'd3);
  assign accept   = rd_go && lat_ok;
  assign cut      = stop_req || (pc_req && (pc_bank == bank_q) && !apc_q);
  assign slot     = accept || ((left_q != '0) && !cut);
  assign beats_m1 = CNT_W'((4'd1 << burst_code) - 4'd1);
  assign sel      = lat_q - 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      bank_q <= '0;
      apc_q  <= 1'b0;
      lat_q  <= 2'd2;
    end else if (accept) begin
      left_q <= beats_m1;
      bank_q <= rd_bank;
      apc_q  <= rd_autopc;
      lat_q  <= lat_code;
    end else if (cut) begin
      left_q <= '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= '0;
      sv[0] <= 1'b0;
      sd[0] <= '0;
    end else begin
      msk_q <= {msk_q[0], mask_in};
      sv[0] <= slot;
      sd[0] <= core_dq;
    end
  end

  for (genvar i = 1; i < NSTG; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sv[i] <= 1'b0;
        sd[i] <= '0;
      end else begin
        sv[i] <= sv[i-1];
        sd[i] <= sd[i-1];
      end
    end
  end

  assign beat_valid = sv[sel];
  assign dq_oe      = beat_valid && !msk_q[1];
  assign dq_out     = dq_oe ? sd[sel] : '0;
endmodule

// File: rtl/sdram_rd_pipe_chk.sv
module sdram_rd_pipe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_go,
  input logic [1:0] lat_code,
  input logic       mask_in,
  input logic       stop_req,
  input logic [1:0] lat_q,
  input logic       dq_oe,
  input logic       beat_valid
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R10
  p_oe_needs_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> beat_valid);

  // R6
  p_mask_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) && $past(mask_in, 2) |-> !dq_oe);

  // R2
  p_first_beat_cl2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) && $past(rd_go && lat_code == 2'd2, 2) && lat_q == 2'd2 |-> beat_valid);

  // R3
  p_first_beat_cl3_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) && $past(rd_go && lat_code == 2'd3, 3) && lat_q == 2'd3 |-> beat_valid);

  // R7
  p_stop_cl2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) && $past(stop_req && !rd_go, 2) && lat_q == 2'd2 && $past(lat_q) == 2'd2
    |-> !beat_valid);

  // R7
  p_stop_cl3_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) && $past(stop_req && !rd_go, 3) && lat_q == 2'd3 && $past(lat_q) == 2'd3
    && $past(lat_q, 2) == 2'd3 |-> !beat_valid);
endmodule

bind sdram_rd_pipe sdram_rd_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .lat_code(lat_code), .mask_in(mask_in),
  .stop_req(stop_req), .lat_q(lat_q), .dq_oe(dq_oe), .beat_valid(beat_valid)
);

// File: tb/sdram_rd_pipe_tb.sv
module sdram_rd_pipe_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_go = 1'b0, rd_autopc = 1'b0, mask_in = 1'b0, stop_req = 1'b0, pc_req = 1'b0;
  logic [1:0] rd_bank = '0, pc_bank = '0, burst_code = '0, lat_code = 2'd2;
  logic [15:0] core_dq = '0;
  logic [15:0] dq_out;
  logic dq_oe, beat_valid;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sdram_rd_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_bank(rd_bank), .rd_autopc(rd_autopc),
    .burst_code(burst_code), .lat_code(lat_code), .core_dq(core_dq), .mask_in(mask_in),
    .stop_req(stop_req), .pc_req(pc_req), .pc_bank(pc_bank),
    .dq_out(dq_out), .dq_oe(dq_oe), .beat_valid(beat_valid)
  );

  // fields: rd, lat, blen, bank, apc, mask, stop, pc, pcbank | exp valid, exp oe, src row
  function automatic logic [20:0] v(input logic rd, input logic [1:0] cl, input logic [1:0] bl,
      input logic [1:0] bk, input logic ap, input logic mk, input logic st, input logic pc,
      input logic [1:0] pb, input logic ev, input logic eo, input logic [5:0] src);
    return {rd, cl, bl, bk, ap, mk, st, pc, pb, ev, eo, src};
  endfunction

  localparam int NROW = 35;
  localparam logic [20:0] TBL [NROW] = '{
    v(0,2,0,0,0,0,0,0,0, 0,0,0),   // 0  idle R10
    v(1,2,3,0,0,0,0,0,0, 0,0,0),   // 1  READ CL2 x8 R2
    v(0,2,0,0,0,0,0,0,0, 1,1,1),   // 2  R2
    v(0,2,0,0,0,0,0,0,0, 1,1,2),   // 3
    v(1,2,1,0,0,0,0,0,0, 1,1,3),   // 4  READ x2 mid-burst R9
    v(0,2,0,0,0,0,0,0,0, 1,1,4),   // 5  R9 no gap
    v(0,2,0,0,0,0,0,0,0, 1,1,5),   // 6
    v(0,2,0,0,0,0,0,0,0, 0,0,0),   // 7  old tail dropped R9
    v(0,2,0,0,0,0,0,0,0, 0,0,0),   // 8
    v(1,3,3,0,0,0,0,0,0, 0,0,0),   // 9  READ CL3 x8 R3
    v(0,3,0,0,0,0,0,0,0, 0,0,0),   // 10
    v(0,3,0,0,0,1,0,0,0, 1,1,9),   // 11 mask raised R6
    v(0,3,0,0,0,0,0,0,0, 1,0,10),  // 12 masked beat R6
    v(0,3,0,0,0,0,1,0,0, 1,1,11),  // 13 stop R7
    v(0,3,0,0,0,0,0,0,0, 1,1,12),  // 14
    v(0,3,0,0,0,0,0,0,0, 0,0,0),   // 15 R7
    v(0,2,0,0,0,0,0,0,0, 0,0,0),   // 16
    v(1,2,2,1,0,0,0,0,0, 0,0,0),   // 17 READ bank1 x4 R8
    v(0,2,0,0,0,0,0,1,2, 1,1,17),  // 18 pc other bank R8
    v(0,2,0,0,0,0,0,1,1, 1,1,18),  // 19 pc same bank R8
    v(0,2,0,0,0,0,0,0,0, 0,0,0),   // 20 R8
    v(0,2,0,0,0,0,0,0,0, 0,0,0),   // 21
    v(1,2,1,0,1,0,0,0,0, 0,0,0),   // 22 READ autopc x2 R8
    v(0,2,0,0,0,0,0,1,0, 1,1,22),  // 23 pc ignored R8
    v(0,2,0,0,0,0,0,0,0, 1,1,23),  // 24
    v(0,2,0,0,0,0,0,0,0, 0,0,0),   // 25
    v(1,2,1,0,0,0,0,0,0, 0,0,0),   // 26 READ x2 R4
    v(1,1,3,0,0,0,0,0,0, 1,1,26),  // 27 READ lat 1 rejected R4
    v(0,2,0,0,0,0,0,0,0, 1,1,27),  // 28
    v(0,2,0,0,0,0,0,0,0, 0,0,0),   // 29 R4
    v(0,2,0,0,0,0,0,0,0, 0,0,0),   // 30
    v(1,2,1,0,0,0,1,0,0, 0,0,0),   // 31 READ+stop R11
    v(0,2,0,0,0,0,0,0,0, 1,1,31),  // 32
    v(0,2,0,0,0,0,0,0,0, 1,1,32),  // 33 R11
    v(0,2,0,0,0,0,0,0,0, 0,0,0)    // 34
  };

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got valid/oe/dq=%h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_go = 0; stop_req = 0; pc_req = 0; mask_in = 0; lat_code = 2'd2;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1 reset", {beat_valid, dq_oe, dq_out}, 18'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      logic [20:0] r;
      logic [15:0] ed;
      r = TBL[i];
      rd_go = r[20]; lat_code = r[19:18]; burst_code = r[17:16]; rd_bank = r[15:14];
      rd_autopc = r[13]; mask_in = r[12]; stop_req = r[11]; pc_req = r[10]; pc_bank = r[9:8];
      core_dq = 16'hC000 + 16'(i);
      @(posedge clk);
      #2;
      ed = r[6] ? 16'hC000 + 16'(r[5:0]) : 16'h0;
      check($sformatf("row %0d R2/R3/R4/R6/R7/R8/R9/R10/R11", i),
            {beat_valid, dq_oe, dq_out}, {r[7], r[6], ed});
      @(negedge clk);
    end

    // R5: beat count per burst code
    for (int j = 0; j < 4; j++) begin
      int cnt;
      cnt = 0;
      idle();
      rd_go = 1; burst_code = 2'(j);
      @(posedge clk);
      #2 if (beat_valid) cnt++;
      @(negedge clk) rd_go = 0;
      for (int k = 0; k < 12; k++) begin
        @(posedge clk);
        #2 if (beat_valid) cnt++;
      end
      @(negedge clk);
      check($sformatf("R5 burst code %0d", j), 18'(cnt), 18'(1 << j));
    end

    // R1: reset in mid-burst clears pipeline and counter
    idle();
    rd_go = 1; burst_code = 2'd3;
    @(negedge clk) rd_go = 0;
    repeat (2) @(negedge clk);
    rst_n = 0;
    #1 check("R1 reset mid-burst", {beat_valid, dq_oe, dq_out}, 18'h0);
    @(negedge clk) rst_n = 1;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 8; k++) begin
        @(posedge clk);
        #2 if (beat_valid) seen++;
      end
      check("R1 no beats after reset", 18'(seen), 18'h0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule